// File: doc/BRIEF.md
# Shared Second-Level Cache with Way-to-Scratchpad Remap

This block is a four-way set-associative second-level cache between a 128-bit processor-side request port and a 128-bit memory-side port. It hides backing-memory latency: hits are served from on-chip storage, and each miss moves whole 32-byte lines, which is two 128-bit beats. The policy is write-back with write-allocate. Only one miss can be outstanding at a time. While a miss is in progress, the processor port holds its ready signal low.

A control register holds a four-bit way-disable mask. A disabled way takes no further part in caching. Its tags are cleared, it never matches, and it is never picked for replacement. Its storage then becomes directly addressable memory inside a fixed address window. Any dirty data in a way at the moment it is disabled is dropped.

Top module: `l2_spm_cache`

## Requirements
- R1: After reset, `req_ready_o` is 1, `rsp_valid_o` is 0, `mem_req_o` is 0, all tags are invalid and the disable mask is 0.
- R2: A read that hits is accepted on clock edge k. `rsp_valid_o` is then 0 at edges k+1 and k+2, and it is 1 with the read data at edge k+3.
- R3: A write that hits, or a write to an enabled window location, is accepted on edge k and answered with `rsp_valid_o`=1 and `rsp_err_o`=0 at edge k+1. A later read of the same address returns the written data.
- R4: A clean miss issues exactly two memory reads and no memory writes. The reads go to the line base address first and to the base address plus 16 second. A read miss returns the beat selected by address bit 4.
- R5: A write miss fills the line from memory, merges the write data into the addressed beat and marks the line dirty, so that the new data is returned by later reads.
- R6: When the victim line is dirty, both of its beats are written to memory at the victim's own address, in beat order, before the first refill read is issued.
- R7: Replacement uses a three-bit tree pseudo-LRU per set, and every hit or fill updates it. The tree starts at way 0. Filling four lines into one set and then hitting the first of them makes the next miss in that set evict the second line filled.
- R8: Setting a mask bit (`ctrl_we_i` with `ctrl_mask_i`, where bit w controls way w) invalidates every line in that way, dirty ones included, without writing them back. While the bit is set, the way never hits and is never chosen as a victim.
- R9: The window starts at `SPM_BASE` and is 2 KiB long. In the window, address bits [10:9] select the way, [8:5] the set and [4] the beat. An access to a disabled way is a hit with no tag check: reads answer at k+3 and writes at k+1, with no memory traffic.
- R10: A window access that addresses a way that is still enabled is answered at edge k+1 with `rsp_valid_o`=1 and `rsp_err_o`=1, and it causes no memory traffic.
- R11: `req_ready_o` stays 0 from acceptance until the response of every request that is not answered at k+1.
- R12: When all four mask bits are set, an access outside the window is answered with an error at edge k+1 and causes no memory traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Load the way-disable mask |
| ctrl_mask_i | input | 4 | New way-disable mask, bit w = way w |
| req_valid_i | input | 1 | Processor request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 32 | Byte address (128-bit aligned) |
| req_wdata_i | input | 128 | Write data |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_err_o | output | 1 | Response is an error |
| rsp_rdata_o | output | 128 | Read data |
| mem_req_o | output | 1 | Memory beat request |
| mem_we_o | output | 1 | Memory beat is a write |
| mem_addr_o | output | 32 | Memory beat address |
| mem_wdata_o | output | 128 | Memory write data |
| mem_ready_i | input | 1 | Memory accepts the beat |
| mem_rvalid_i | input | 1 | Read beat returned |
| mem_rdata_i | input | 128 | Returned read data |

## Verification
The hardest case to reach from the ports is a replacement decision in which the tree points at a disabled way and the victim logic must steer around it. The stimulus first fills every way of one set in a known order and hits one line so that the tree state is known. It then disables way 2, which still holds a line, and issues misses until the tree selects way 2. Scratchpad data written to that way is read back afterwards to show that the refill never overwrote it. The memory model accepts a beat only on every other cycle, so handshake stalls also occur during write-back and refill.

// File: rtl/l2_spm_pkg.sv
package l2_spm_pkg;
  localparam int NUM_WAYS = 4;
  localparam int WAY_W    = 2;
  localparam int PLRU_W   = NUM_WAYS - 1;

  typedef enum logic [2:0] {
    S_IDLE, S_RD1, S_RD2, S_WB, S_FILL, S_DONE
  } l2_state_e;

  // tree bits: [0] root (1 = right pair), [1] left pair, [2] right pair
  function automatic logic [PLRU_W-1:0] plru_touch(input logic [PLRU_W-1:0] b,
                                                   input logic [WAY_W-1:0] w);
    logic [PLRU_W-1:0] n;
    n = b;
    n[0] = ~w[1];
    if (!w[1]) n[1] = ~w[0];
    else       n[2] = ~w[0];
    return n;
  endfunction
endpackage

// File: rtl/l2_plru.sv
module l2_plru
  import l2_spm_pkg::*;
#(
  parameter int NUM_SETS = 16,
  localparam int SET_W = $clog2(NUM_SETS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_WAYS-1:0] mask_i,
  input  logic [SET_W-1:0]  lk_set_i,
  output logic [WAY_W-1:0]  victim_o,
  input  logic              upd_en_i,
  input  logic [SET_W-1:0]  upd_set_i,
  input  logic [WAY_W-1:0]  upd_way_i
);
  logic [PLRU_W-1:0] tree_q [NUM_SETS];
  logic [PLRU_W-1:0] cur;
  logic left_ok, right_ok, go_right, sel;

  assign cur      = tree_q[lk_set_i];
  assign left_ok  = ~(mask_i[0] & mask_i[1]);
  assign right_ok = ~(mask_i[2] & mask_i[3]);

  always_comb begin
    go_right = cur[0];
    if (!left_ok)       go_right = 1'b1;
    else if (!right_ok) go_right = 1'b0;
    if (go_right) begin
      sel = cur[2];
      if (mask_i[2])      sel = 1'b1;
      else if (mask_i[3]) sel = 1'b0;
    end else begin
      sel = cur[1];
      if (mask_i[0])      sel = 1'b1;
      else if (mask_i[1]) sel = 1'b0;
    end
    victim_o = {go_right, sel};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NUM_SETS; s++) tree_q[s] <= '0;
    end else if (upd_en_i) begin
      tree_q[upd_set_i] <= plru_touch(tree_q[upd_set_i], upd_way_i);
    end
  end

  // R8
  victim_enabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&mask_i) |-> !mask_i[victim_o]);
endmodule

// File: rtl/l2_tag_store.sv
module l2_tag_store
  import l2_spm_pkg::*;
#(
  parameter int NUM_SETS = 16,
  parameter int TAG_W    = 23,
  localparam int SET_W = $clog2(NUM_SETS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_WAYS-1:0] mask_i,
  input  logic [SET_W-1:0]    lk_set_i,
  input  logic [TAG_W-1:0]    lk_tag_i,
  output logic                hit_o,
  output logic [WAY_W-1:0]    hit_way_o,
  input  logic [SET_W-1:0]    vc_set_i,
  input  logic [WAY_W-1:0]    vc_way_i,
  output logic                vc_dirty_o,
  output logic [TAG_W-1:0]    vc_tag_o,
  input  logic                ins_en_i,
  input  logic [SET_W-1:0]    ins_set_i,
  input  logic [WAY_W-1:0]    ins_way_i,
  input  logic [TAG_W-1:0]    ins_tag_i,
  input  logic                ins_dirty_i,
  input  logic                mark_en_i,
  input  logic [SET_W-1:0]    mark_set_i,
  input  logic [WAY_W-1:0]    mark_way_i
);
  logic [NUM_WAYS-1:0] valid_q [NUM_SETS];
  logic [NUM_WAYS-1:0] dirty_q [NUM_SETS];
  logic [TAG_W-1:0]    tag_q   [NUM_WAYS][NUM_SETS];
  logic [NUM_WAYS-1:0] hit_vec;
  logic [NUM_WAYS-1:0] way_live;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    assign hit_vec[w] = valid_q[lk_set_i][w] && !mask_i[w] &&
                        (tag_q[w][lk_set_i] == lk_tag_i);
    always_comb begin
      way_live[w] = 1'b0;
      for (int s = 0; s < NUM_SETS; s++) way_live[w] |= valid_q[s][w];
    end
    // R8
    dis_inval_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mask_i[w] |=> (!mask_i[w] || !way_live[w]));
  end

  always_comb begin
    hit_way_o = '0;
    for (int w = 0; w < NUM_WAYS; w++)
      if (hit_vec[w]) hit_way_o = WAY_W'(w);
  end
  assign hit_o      = |hit_vec;
  assign vc_dirty_o = valid_q[vc_set_i][vc_way_i] && dirty_q[vc_set_i][vc_way_i];
  assign vc_tag_o   = tag_q[vc_way_i][vc_set_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
      end
    end else begin
      if (ins_en_i) begin
        valid_q[ins_set_i][ins_way_i] <= !mask_i[ins_way_i];
        dirty_q[ins_set_i][ins_way_i] <= ins_dirty_i;
      end
      if (mark_en_i) dirty_q[mark_set_i][mark_way_i] <= 1'b1;
      for (int w = 0; w < NUM_WAYS; w++)
        if (mask_i[w])
          for (int s = 0; s < NUM_SETS; s++) valid_q[s][w] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (ins_en_i) tag_q[ins_way_i][ins_set_i] <= ins_tag_i;
  end

  // R8
  one_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));
endmodule

// File: rtl/l2_data_store.sv
module l2_data_store
  import l2_spm_pkg::*;
#(
  parameter int DATA_W   = 128,
  parameter int NUM_SETS = 16,
  parameter int BEATS    = 2,
  localparam int SET_W  = $clog2(NUM_SETS),
  localparam int BEAT_W = $clog2(BEATS),
  localparam int IDX_W  = WAY_W + SET_W + BEAT_W,
  localparam int DEPTH  = NUM_WAYS * NUM_SETS * BEATS
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  ridx_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[widx_i] <= wdata_i;
  end
  assign rdata_o = mem_q[ridx_i];
endmodule

// File: rtl/l2_spm_cache.sv
module l2_spm_cache
  import l2_spm_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 128,
  parameter int LINE_BYTES = 32,
  parameter int NUM_SETS   = 16,
  parameter logic [31:0] SPM_BASE = 32'hF000_0000
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ctrl_we_i,
  input  logic [NUM_WAYS-1:0] ctrl_mask_i,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic                req_write_i,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic [DATA_W-1:0]   req_wdata_i,
  output logic                rsp_valid_o,
  output logic                rsp_err_o,
  output logic [DATA_W-1:0]   rsp_rdata_o,
  output logic                mem_req_o,
  output logic                mem_we_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [DATA_W-1:0]   mem_wdata_o,
  input  logic                mem_ready_i,
  input  logic                mem_rvalid_i,
  input  logic [DATA_W-1:0]   mem_rdata_i
);
  localparam int OFF_W  = $clog2(DATA_W / 8);
  localparam int BEATS  = LINE_BYTES / (DATA_W / 8);
  localparam int BEAT_W = $clog2(BEATS);
  localparam int SET_W  = $clog2(NUM_SETS);
  localparam int TAG_W  = ADDR_W - OFF_W - BEAT_W - SET_W;
  localparam int WIN_W  = OFF_W + BEAT_W + SET_W + WAY_W;
  localparam int CNT_W  = BEAT_W + 1;
  localparam int IDX_W  = WAY_W + SET_W + BEAT_W;

  l2_state_e state_q;
  logic [NUM_WAYS-1:0] mask_q;
  logic                is_wr_q;
  logic [TAG_W-1:0]    tag_q, vtag_q;
  logic [SET_W-1:0]    set_q;
  logic [BEAT_W-1:0]   beat_q;
  logic [WAY_W-1:0]    way_q;
  logic [DATA_W-1:0]   wdata_q, cap_q;
  logic [CNT_W-1:0]    cnt_q, rcv_q;

  // request field decode
  logic [BEAT_W-1:0] r_beat;
  logic [SET_W-1:0]  r_set;
  logic [TAG_W-1:0]  r_tag;
  logic [WAY_W-1:0]  r_wway;
  logic in_win, all_dis, accept, spm_ok, bad, c_hit, c_miss;
  logic hit;
  logic [WAY_W-1:0] hit_way, victim;
  logic vc_dirty;
  logic [TAG_W-1:0] vc_tag;

  assign r_beat  = req_addr_i[OFF_W +: BEAT_W];
  assign r_set   = req_addr_i[OFF_W+BEAT_W +: SET_W];
  assign r_tag   = req_addr_i[ADDR_W-1 -: TAG_W];
  assign r_wway  = req_addr_i[OFF_W+BEAT_W+SET_W +: WAY_W];
  assign in_win  = req_addr_i[ADDR_W-1:WIN_W] == SPM_BASE[ADDR_W-1:WIN_W];
  assign all_dis = &mask_q;
  assign req_ready_o = (state_q == S_IDLE);
  assign accept  = req_ready_o && req_valid_i;
  assign spm_ok  = in_win && mask_q[r_wway];
  assign bad     = (in_win && !mask_q[r_wway]) || (!in_win && all_dis);
  assign c_hit   = !in_win && !all_dis && hit;
  assign c_miss  = !in_win && !all_dis && !hit;

  // tag store ports
  logic ins_en, mark_en, plru_upd;
  logic [WAY_W-1:0] plru_way;
  logic [SET_W-1:0] plru_set;

  assign ins_en   = (state_q == S_DONE);
  assign mark_en  = accept && req_write_i && c_hit;
  assign plru_upd = (accept && c_hit) || ins_en;
  assign plru_way = ins_en ? way_q : hit_way;
  assign plru_set = ins_en ? set_q : r_set;

  l2_tag_store #(.NUM_SETS(NUM_SETS), .TAG_W(TAG_W)) u_tags (
    .clk_i, .rst_ni,
    .mask_i(mask_q),
    .lk_set_i(r_set), .lk_tag_i(r_tag),
    .hit_o(hit), .hit_way_o(hit_way),
    .vc_set_i(r_set), .vc_way_i(victim),
    .vc_dirty_o(vc_dirty), .vc_tag_o(vc_tag),
    .ins_en_i(ins_en), .ins_set_i(set_q), .ins_way_i(way_q),
    .ins_tag_i(tag_q), .ins_dirty_i(is_wr_q),
    .mark_en_i(mark_en), .mark_set_i(r_set), .mark_way_i(hit_way)
  );

  l2_plru #(.NUM_SETS(NUM_SETS)) u_plru (
    .clk_i, .rst_ni,
    .mask_i(mask_q),
    .lk_set_i(r_set),
    .victim_o(victim),
    .upd_en_i(plru_upd), .upd_set_i(plru_set), .upd_way_i(plru_way)
  );

  // data store ports
  logic              d_we;
  logic [IDX_W-1:0]  d_widx, d_ridx;
  logic [DATA_W-1:0] d_wdata, d_rdata;

  always_comb begin
    d_we    = 1'b0;
    d_widx  = {way_q, set_q, beat_q};
    d_wdata = wdata_q;
    unique case (state_q)
      S_IDLE: begin
        d_we    = accept && req_write_i && (spm_ok || c_hit);
        d_widx  = {spm_ok ? r_wway : hit_way, r_set, r_beat};
        d_wdata = req_wdata_i;
      end
      S_FILL: begin
        d_we    = mem_rvalid_i;
        d_widx  = {way_q, set_q, rcv_q[BEAT_W-1:0]};
        d_wdata = mem_rdata_i;
      end
      S_DONE:  d_we = is_wr_q;
      default: d_we = 1'b0;
    endcase
  end
  assign d_ridx = (state_q == S_WB) ? {way_q, set_q, cnt_q[BEAT_W-1:0]}
                                    : {way_q, set_q, beat_q};

  l2_data_store #(.DATA_W(DATA_W), .NUM_SETS(NUM_SETS), .BEATS(BEATS)) u_data (
    .clk_i,
    .we_i(d_we), .widx_i(d_widx), .wdata_i(d_wdata),
    .ridx_i(d_ridx), .rdata_o(d_rdata)
  );

  // memory side
  assign mem_req_o   = (state_q == S_WB) ||
                       ((state_q == S_FILL) && (cnt_q < CNT_W'(BEATS)));
  assign mem_we_o    = (state_q == S_WB);
  assign mem_addr_o  = {(state_q == S_WB) ? vtag_q : tag_q, set_q,
                        cnt_q[BEAT_W-1:0], {OFF_W{1'b0}}};
  assign mem_wdata_o = d_rdata;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else if (ctrl_we_i) mask_q <= ctrl_mask_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      is_wr_q     <= 1'b0;
      tag_q       <= '0;
      vtag_q      <= '0;
      set_q       <= '0;
      beat_q      <= '0;
      way_q       <= '0;
      wdata_q     <= '0;
      cap_q       <= '0;
      cnt_q       <= '0;
      rcv_q       <= '0;
      rsp_valid_o <= 1'b0;
      rsp_err_o   <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= 1'b0;
      rsp_err_o   <= 1'b0;
      unique case (state_q)
        S_IDLE: if (accept) begin
          is_wr_q <= req_write_i;
          tag_q   <= r_tag;
          set_q   <= r_set;
          beat_q  <= r_beat;
          wdata_q <= req_wdata_i;
          cnt_q   <= '0;
          rcv_q   <= '0;
          if (bad) begin
            rsp_valid_o <= 1'b1;
            rsp_err_o   <= 1'b1;
          end else if (spm_ok || c_hit) begin
            way_q <= spm_ok ? r_wway : hit_way;
            if (req_write_i) rsp_valid_o <= 1'b1;
            else             state_q     <= S_RD1;
          end else if (c_miss) begin
            way_q   <= victim;
            vtag_q  <= vc_tag;
            state_q <= vc_dirty ? S_WB : S_FILL;
          end
        end
        S_RD1: state_q <= S_RD2;
        S_RD2: begin
          rsp_valid_o <= 1'b1;
          rsp_rdata_o <= d_rdata;
          state_q     <= S_IDLE;
        end
        S_WB: if (mem_ready_i) begin
          if (cnt_q == CNT_W'(BEATS - 1)) begin
            cnt_q   <= '0;
            state_q <= S_FILL;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_FILL: begin
          if (mem_req_o && mem_ready_i) cnt_q <= cnt_q + 1'b1;
          if (mem_rvalid_i) begin
            if (rcv_q[BEAT_W-1:0] == beat_q) cap_q <= mem_rdata_i;
            rcv_q <= rcv_q + 1'b1;
            if (rcv_q == CNT_W'(BEATS - 1)) state_q <= S_DONE;
          end
        end
        S_DONE: begin
          rsp_valid_o <= 1'b1;
          if (!is_wr_q) rsp_rdata_o <= cap_q;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R2
  rd_hit_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !req_write_i && (c_hit || spm_ok))
      |=> !rsp_valid_o ##1 !rsp_valid_o ##1 (rsp_valid_o && !rsp_err_o));
  // R3
  wr_hit_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && req_write_i && (c_hit || spm_ok)) |=> (rsp_valid_o && !rsp_err_o));
  // R10
  win_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && bad) |=> (rsp_valid_o && rsp_err_o && !mem_req_o));
  // R6
  wb_before_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> !mem_rvalid_i);
endmodule

// File: tb/tb_l2_spm_cache.sv
module tb_l2_spm_cache;
  localparam int CLK_PERIOD = 10;

  logic clk, rst_n;
  logic ctrl_we; logic [3:0] ctrl_mask;
  logic req_valid, req_ready, req_write;
  logic [31:0] req_addr; logic [127:0] req_wdata;
  logic rsp_valid, rsp_err; logic [127:0] rsp_rdata;
  logic mem_req, mem_we, mem_ready, mem_rvalid;
  logic [31:0] mem_addr; logic [127:0] mem_wdata, mem_rdata;

  l2_spm_cache dut (
    .clk_i(clk), .rst_ni(rst_n),
    .ctrl_we_i(ctrl_we), .ctrl_mask_i(ctrl_mask),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err), .rsp_rdata_o(rsp_rdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ready_i(mem_ready),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;

  // backing memory model and traffic log
  logic [127:0] mem_store [logic [31:0]];
  logic [127:0] shadow    [logic [31:0]];
  logic         lg_we   [512];
  logic [31:0]  lg_addr [512];
  int lg_n = 0;

  function automatic logic [127:0] init_word(input logic [31:0] a);
    return {4{a ^ 32'h5A5A_0000}};
  endfunction
  function automatic logic [127:0] mem_word(input logic [31:0] a);
    return mem_store.exists(a) ? mem_store[a] : init_word(a);
  endfunction
  function automatic logic [127:0] exp_word(input logic [31:0] a);
    return shadow.exists(a) ? shadow[a] : init_word(a);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ready  <= 1'b0;
      mem_rvalid <= 1'b0;
      mem_rdata  <= '0;
    end else begin
      mem_rvalid <= 1'b0;
      if (mem_req && mem_ready) begin
        if (lg_n < 512) begin
          lg_we[lg_n]   = mem_we;
          lg_addr[lg_n] = mem_addr;
          lg_n++;
        end
        if (mem_we) mem_store[mem_addr] = mem_wdata;
        else begin
          mem_rvalid <= 1'b1;
          mem_rdata  <= mem_word(mem_addr);
        end
      end
      mem_ready <= ~mem_ready;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic set_mask(input logic [3:0] m);
    @(negedge clk);
    ctrl_we = 1'b1; ctrl_mask = m;
    @(negedge clk);
    ctrl_we = 1'b0;
    @(negedge clk);
  endtask

  // drives one request; lat = edges from acceptance to the response
  task automatic do_req(input logic we, input logic [31:0] a, input logic [127:0] d,
                        output int lat, output logic [127:0] rd, output logic er,
                        output bit stall_ok, output int l0);
    @(negedge clk);
    req_valid = 1'b1; req_write = we; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    l0 = lg_n;
    @(posedge clk);
    lat = 0; stall_ok = 1;
    do begin
      @(negedge clk);
      req_valid = 1'b0;
      lat++;
      if (!rsp_valid && req_ready) stall_ok = 0;
    end while (!rsp_valid && lat < 200);
    rd = rsp_rdata; er = rsp_err;
  endtask

  task automatic count_mem(input int l0, output int nrd, output int nwr);
    nrd = 0; nwr = 0;
    for (int i = l0; i < lg_n; i++) if (lg_we[i]) nwr++; else nrd++;
  endtask

  typedef struct packed {
    logic        we;
    logic [31:0] addr;
    logic [31:0] seed;
    logic [1:0]  lat;   // 0 = miss, else 1 or 3 edges
    logic [1:0]  nrd;
    logic [1:0]  nwr;
    logic [31:0] wb;    // victim line base when nwr != 0
  } vec_t;

  // set 3 lines: A=0x060 B=0x260 C=0x460 D=0x660 E=0x860
  localparam vec_t VECS [13] = '{
    '{1'b0, 32'h060, 32'h0,        2'd0, 2'd2, 2'd0, 32'h0},   // R4 fill way0
    '{1'b0, 32'h070, 32'h0,        2'd3, 2'd0, 2'd0, 32'h0},   // R2 second beat
    '{1'b1, 32'h060, 32'h1111_1111,2'd1, 2'd0, 2'd0, 32'h0},   // R3
    '{1'b0, 32'h060, 32'h0,        2'd3, 2'd0, 2'd0, 32'h0},   // R3 read back
    '{1'b1, 32'h260, 32'h2222_2222,2'd0, 2'd2, 2'd0, 32'h0},   // R5 way2
    '{1'b0, 32'h260, 32'h0,        2'd3, 2'd0, 2'd0, 32'h0},   // R5
    '{1'b0, 32'h460, 32'h0,        2'd0, 2'd2, 2'd0, 32'h0},   // way1
    '{1'b0, 32'h660, 32'h0,        2'd0, 2'd2, 2'd0, 32'h0},   // way3
    '{1'b0, 32'h060, 32'h0,        2'd3, 2'd0, 2'd0, 32'h0},   // R7 touch A
    '{1'b0, 32'h860, 32'h0,        2'd0, 2'd2, 2'd2, 32'h260}, // R6 R7 evicts B
    '{1'b0, 32'h060, 32'h0,        2'd3, 2'd0, 2'd0, 32'h0},
    '{1'b0, 32'h260, 32'h0,        2'd0, 2'd2, 2'd0, 32'h0},   // R6 data came back
    '{1'b1, 32'h070, 32'h3333_3333,2'd1, 2'd0, 2'd0, 32'h0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int lat, l0, nrd, nwr;
    logic [127:0] rd;
    logic er;
    bit st;
    rst_n = 0; ctrl_we = 0; ctrl_mask = '0;
    req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready after reset", 128'(req_ready), 128'd1);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 128'(rsp_valid), 128'd0);
    chk(mem_req == 1'b0, "R1", "mem_req after reset", 128'(mem_req), 128'd0);

    foreach (VECS[i]) begin
      vec_t v;
      logic [127:0] wd;
      v  = VECS[i];
      wd = {4{v.seed}};
      do_req(v.we, v.addr, wd, lat, rd, er, st, l0);
      count_mem(l0, nrd, nwr);
      if (v.lat == 0) chk(lat > 3, "R4", $sformatf("v%0d miss latency", i), 128'(lat), 128'd4);
      else            chk(lat == int'(v.lat), (v.lat == 1) ? "R3" : "R2",
                          $sformatf("v%0d hit latency", i), 128'(lat), 128'(v.lat));
      chk(er == 1'b0, "R3", $sformatf("v%0d no error", i), 128'(er), 128'd0);
      chk(nrd == int'(v.nrd) && nwr == int'(v.nwr), "R4",
          $sformatf("v%0d mem beats rd/wr", i), 128'({nrd[7:0], nwr[7:0]}),
          128'({6'd0, v.nrd, 6'd0, v.nwr}));
      if (v.lat != 1) chk(st, "R11", $sformatf("v%0d ready low while busy", i), 128'(st), 128'd1);
      if (v.we) shadow[v.addr] = wd;
      else chk(rd == exp_word(v.addr), (i == 11) ? "R6" : "R4",
               $sformatf("v%0d read data", i), rd, exp_word(v.addr));
      if (v.nrd == 2 && l0 + nwr + 2 <= lg_n) begin
        chk(!lg_we[l0 + nwr] && lg_addr[l0 + nwr] == {v.addr[31:5], 5'h00} &&
            lg_addr[l0 + nwr + 1] == {v.addr[31:5], 5'h10}, "R4",
            $sformatf("v%0d refill order", i), 128'(lg_addr[l0 + nwr]), 128'({v.addr[31:5], 5'h00}));
      end
      if (v.nwr == 2 && nwr == 2) begin
        chk(lg_we[l0] && lg_we[l0 + 1] && lg_addr[l0] == v.wb && lg_addr[l0 + 1] == v.wb + 32'h10,
            "R6", "writeback before refill", 128'(lg_addr[l0]), 128'(v.wb));
      end
    end

    // disable way 2 (held E, clean), use it as scratchpad
    set_mask(4'b0100);
    do_req(1'b1, 32'hF000_0460, {4{32'h4444_4444}}, lat, rd, er, st, l0);
    count_mem(l0, nrd, nwr);
    chk(lat == 1 && !er && nrd == 0 && nwr == 0, "R9", "window write", 128'(lat), 128'd1);
    do_req(1'b0, 32'hF000_0460, '0, lat, rd, er, st, l0);
    chk(lat == 3 && !er, "R9", "window read latency", 128'(lat), 128'd3);
    chk(rd == {4{32'h4444_4444}}, "R9", "window read data", rd, {4{32'h4444_4444}});
    do_req(1'b0, 32'hF000_0060, '0, lat, rd, er, st, l0);
    count_mem(l0, nrd, nwr);
    chk(lat == 1 && er && nrd == 0 && nwr == 0, "R10", "enabled-way window error",
        128'({lat[7:0], 7'd0, er}), 128'h101);

    // E was in disabled way2: must miss; victims must avoid way2
    do_req(1'b0, 32'h860, '0, lat, rd, er, st, l0);
    count_mem(l0, nrd, nwr);
    chk(lat > 3 && nrd == 2 && nwr == 0, "R8", "disabled way tag cleared", 128'(lat), 128'd4);
    chk(rd == exp_word(32'h860), "R8", "refetched data", rd, exp_word(32'h860));
    do_req(1'b0, 32'hA60, '0, lat, rd, er, st, l0);
    chk(lat > 3, "R7", "F miss", 128'(lat), 128'd4);
    do_req(1'b0, 32'hC60, '0, lat, rd, er, st, l0);
    chk(lat > 3 && rd == exp_word(32'hC60), "R8", "G miss steered off way2", rd, exp_word(32'hC60));
    do_req(1'b0, 32'hA60, '0, lat, rd, er, st, l0);
    chk(lat == 3, "R7", "F still resident", 128'(lat), 128'd3);
    do_req(1'b0, 32'hF000_0460, '0, lat, rd, er, st, l0);
    chk(rd == {4{32'h4444_4444}}, "R8", "scratchpad untouched by refill", rd, {4{32'h4444_4444}});

    // all ways disabled
    set_mask(4'b1111);
    do_req(1'b0, 32'h060, '0, lat, rd, er, st, l0);
    count_mem(l0, nrd, nwr);
    chk(lat == 1 && er && nrd == 0, "R12", "all disabled error", 128'({lat[7:0], 7'd0, er}), 128'h101);

    // re-enable: dirty A was dropped, no writeback
    set_mask(4'b0000);
    do_req(1'b0, 32'h060, '0, lat, rd, er, st, l0);
    count_mem(l0, nrd, nwr);
    chk(lat > 3 && nrd == 2 && nwr == 0, "R8", "invalidated dirty line not written back",
        128'({nrd[7:0], nwr[7:0]}), 128'h0200);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule